// File: doc/BRIEF.md
# Boot and Power Control Registers

This block is a small register bank on a 32-bit read/write register bus. It serves a multicore device and holds three registers. The first is a set of per-core boot-complete flags that software can set but never clear. The second is a power-state word that tells boot software which power-saving mode the device is in, and where to resume after hibernation. The third is a trigger register: writing a one to it sends a one-cycle non-maskable interrupt pulse to its target core.

The registers sit in two reset domains. The boot flags and the interrupt pulse clear on either reset. The power-state word clears only on power-on reset, so its contents survive a warm reset. Power-on reset also puts the warm-reset domain into reset.

The bus has one cycle per access. A write takes effect at the clock edge where `bus_sel` and `bus_we` are both high. Read data is combinational from the address while `bus_sel` is high and `bus_we` is low.

Top module: `boot_pwr_regs`

## Requirements
- R1: A write to offset 0x0 ORs `bus_wdata[NUM_CORES-1:0]` into the boot-complete flags. Several flags can be set by one write. The new flags appear on `boot_done` after that clock edge.
- R2: Writing 0 to a set boot-complete flag leaves it set.
- R3: Both warm reset (`warm_rst_n` low) and power-on reset (`por_n` low) clear all boot-complete flags to 0.
- R4: A write to offset 0x4 loads the full 32-bit power-state word. Warm reset leaves the word unchanged. Only power-on reset clears it to 0.
- R5: Power-state fields are decoded as follows:
  - bit 0 is `pwr_standby`;
  - bit 1 is `pwr_hibernate`;
  - bit 2 is `pwr_hib_mode2` (0 selects mode 1, 1 selects mode 2);
  - bits 31:3 are `pwr_resume_addr`.

  A read of offset 0x4 returns the whole word.
- R6: A write to offset 0x8 with `bus_wdata[0]=1` raises `nmi_pulse` for exactly the one cycle after that clock edge.
- R7: A write to offset 0x8 with `bus_wdata[0]=0` causes no pulse. A read of offset 0x8 returns 0 and causes no pulse.
- R8: Writes of 1 to offset 0x8 in consecutive cycles give `nmi_pulse` high for the same number of consecutive cycles.
- R9: Reads of any offset other than 0x0, 0x4 and 0x8 return 0. Writes to such offsets change no register.
- R10: A read of offset 0x0 returns the boot-complete flags in bits `NUM_CORES-1:0`, with zeros above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| warm_rst_n | input | 1 | Warm reset, active low, asynchronous assert |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| boot_done | output | NUM_CORES | Boot-complete flags |
| pwr_standby | output | 1 | Standby flag |
| pwr_hibernate | output | 1 | Hibernation flag |
| pwr_hib_mode2 | output | 1 | Hibernation mode select |
| pwr_resume_addr | output | 29 | Recovery branch address |
| nmi_pulse | output | 1 | Non-maskable interrupt pulse to the target core |

## Verification
Every register drives a port directly. A wrongly cleared or wrongly set boot flag therefore shows on `boot_done` in the cycle after the faulty edge or reset. A power-state word disturbed by warm reset shows on the decoded field outputs as soon as that reset asserts, and also on a read of offset 0x4. A stuck or missing interrupt pulse is seen on `nmi_pulse` one cycle after the trigger write. The bench samples `nmi_pulse` in every cycle around a trigger, so a pulse that is too long or absent is caught.

// File: rtl/boot_pwr_regs.sv
module boot_pwr_regs #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 4
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 warm_rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_CORES-1:0] boot_done,
  output logic                 pwr_standby,
  output logic                 pwr_hibernate,
  output logic                 pwr_hib_mode2,
  output logic [28:0]          pwr_resume_addr,
  output logic                 nmi_pulse
);
  localparam logic [ADDR_W-1:0] OFS_BOOT = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] OFS_PWR  = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] OFS_NMI  = ADDR_W'(4'h8);
  localparam int PAD_W = 32 - NUM_CORES;

  logic                 warm_n;
  logic                 wr, wr_boot, wr_pwr, fire;
  logic [NUM_CORES-1:0] boot_q;
  logic [31:0]          pwr_q;
  logic                 nmi_q;

  assign warm_n  = por_n & warm_rst_n;
  assign wr      = bus_sel & bus_we;
  assign wr_boot = wr && (bus_addr == OFS_BOOT);
  assign wr_pwr  = wr && (bus_addr == OFS_PWR);
  assign fire    = wr && (bus_addr == OFS_NMI) && bus_wdata[0];

  always_ff @(posedge clk or negedge warm_n)
    if (!warm_n)      boot_q <= '0;
    else if (wr_boot) boot_q <= boot_q | bus_wdata[NUM_CORES-1:0];

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)      pwr_q <= '0;
    else if (wr_pwr) pwr_q <= bus_wdata;

  always_ff @(posedge clk or negedge warm_n)
    if (!warm_n) nmi_q <= 1'b0;
    else         nmi_q <= fire;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      if (bus_addr == OFS_BOOT)     bus_rdata = {{PAD_W{1'b0}}, boot_q};
      else if (bus_addr == OFS_PWR) bus_rdata = pwr_q;
    end
  end

  assign boot_done       = boot_q;
  assign pwr_standby     = pwr_q[0];
  assign pwr_hibernate   = pwr_q[1];
  assign pwr_hib_mode2   = pwr_q[2];
  assign pwr_resume_addr = pwr_q[31:3];
  assign nmi_pulse       = nmi_q;

  // R2
  boot_sticky_chk: assert property (@(posedge clk) disable iff (!warm_n)
    ($past(boot_q) & ~boot_q) == '0);

  // R1
  boot_set_chk: assert property (@(posedge clk) disable iff (!warm_n)
    wr_boot |=> ((boot_q & $past(bus_wdata[NUM_CORES-1:0])) == $past(bus_wdata[NUM_CORES-1:0])));

  // R4
  pwr_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    !wr_pwr |=> $stable(pwr_q));

  // R4
  pwr_load_chk: assert property (@(posedge clk) disable iff (!por_n)
    wr_pwr |=> pwr_q == $past(bus_wdata));

  // R6
  nmi_fire_chk: assert property (@(posedge clk) disable iff (!warm_n)
    fire |=> nmi_pulse);

  // R6
  nmi_single_chk: assert property (@(posedge clk) disable iff (!warm_n)
    !fire |=> !nmi_pulse);

  // R7
  nmi_read_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    (bus_sel && !bus_we && bus_addr == OFS_NMI) |-> bus_rdata == 32'h0);
endmodule

// File: tb/boot_pwr_regs_tb.sv
module boot_pwr_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic por_n = 1'b0, warm_rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NC-1:0] boot_done;
  logic pwr_standby, pwr_hibernate, pwr_hib_mode2, nmi_pulse;
  logic [28:0] pwr_resume_addr;
  int checks = 0, errors = 0;

  boot_pwr_regs #(.NUM_CORES(NC), .ADDR_W(4)) dut_i (
    .clk, .por_n, .warm_rst_n, .bus_sel, .bus_we, .bus_addr, .bus_wdata,
    .bus_rdata, .boot_done, .pwr_standby, .pwr_hibernate, .pwr_hib_mode2,
    .pwr_resume_addr, .nmi_pulse);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  function automatic logic [31:0] pwr_out();
    return {pwr_resume_addr, pwr_hib_mode2, pwr_hibernate, pwr_standby};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    check("R3 reset boot", 32'(boot_done), 0);
    check("R4 reset pwr", pwr_out(), 0);
    check("R6 reset nmi", 32'(nmi_pulse), 0);
    rd(4'h0, d); check("R10 reset read boot", d, 0);
  endtask

  task automatic t_boot();
    logic [31:0] d;
    wr(4'h0, 32'h0000_0005);
    check("R1 set two flags", 32'(boot_done), 32'h5);
    wr(4'h0, 32'h0000_0002);
    check("R1 OR in flag", 32'(boot_done), 32'h7);
    wr(4'h0, 32'h0000_0000);
    check("R2 write zero keeps", 32'(boot_done), 32'h7);
    wr(4'h0, 32'hFFFF_FFF8);
    check("R1 upper bits set core3", 32'(boot_done), 32'hF);
    rd(4'h0, d); check("R10 read boot", d, 32'h0000_000F);
  endtask

  task automatic t_power();
    logic [31:0] d;
    wr(4'h4, 32'hDEAD_BEE5);
    check("R5 standby", 32'(pwr_standby), 1);
    check("R5 hibernate", 32'(pwr_hibernate), 0);
    check("R5 mode2", 32'(pwr_hib_mode2), 1);
    check("R5 resume addr", 32'(pwr_resume_addr), 32'hDEAD_BEE5 >> 3);
    rd(4'h4, d); check("R5 read pwr", d, 32'hDEAD_BEE5);
    wr(4'h4, 32'h1234_5672);
    check("R4 reload", pwr_out(), 32'h1234_5672);
  endtask

  task automatic t_nmi();
    logic [31:0] d;
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 4'h8; bus_wdata = 32'h1;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    check("R6 pulse high", 32'(nmi_pulse), 1);
    @(negedge clk);
    check("R6 pulse one cycle", 32'(nmi_pulse), 0);
    wr(4'h8, 32'hFFFF_FFFE);
    check("R7 write zero no pulse", 32'(nmi_pulse), 0);
    rd(4'h8, d);
    check("R7 read zero", d, 0);
    check("R7 read no pulse", 32'(nmi_pulse), 0);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 4'h8; bus_wdata = 32'h1;
    @(negedge clk);
    check("R8 first pulse", 32'(nmi_pulse), 1);
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    check("R8 second pulse", 32'(nmi_pulse), 1);
    @(negedge clk);
    check("R8 ends", 32'(nmi_pulse), 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(4'hC, 32'hFFFF_FFFF);
    wr(4'h2, 32'hFFFF_FFFF);
    check("R9 pwr untouched", pwr_out(), 32'h1234_5672);
    check("R9 nmi untouched", 32'(nmi_pulse), 0);
    rd(4'hC, d); check("R9 read unmapped", d, 0);
    rd(4'h4, d); check("R9 pwr read back", d, 32'h1234_5672);
  endtask

  task automatic t_warm();
    @(negedge clk); warm_rst_n = 0;
    #1;
    check("R3 warm clears boot", 32'(boot_done), 0);
    check("R4 warm keeps pwr", pwr_out(), 32'h1234_5672);
    @(negedge clk); warm_rst_n = 1;
    @(negedge clk);
    check("R4 after warm pwr", pwr_out(), 32'h1234_5672);
  endtask

  task automatic t_por();
    wr(4'h0, 32'h9);
    check("R1 set before por", 32'(boot_done), 32'h9);
    @(negedge clk); por_n = 0;
    #1;
    check("R3 por clears boot", 32'(boot_done), 0);
    check("R4 por clears pwr", pwr_out(), 0);
    @(negedge clk); por_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1; warm_rst_n = 1;
    @(negedge clk);
    t_reset();
    t_boot();
    t_power();
    t_nmi();
    t_unmapped();
    t_warm();
    t_por();
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule